// File: doc/BRIEF.md
# Dynamic Fixed-Point Scale Tracker

This block follows the shared power-of-two exponent of one tensor stored as 8-bit signed codes, where a code `x` stands for the real value `x·2^e`. During a batch, the tensor's elements arrive as a stream of 32-bit signed integers with a fixed binary point. A start marker opens the tensor and an end marker closes it. For every accepted element the block tests two things. The first is whether the element would leave the code range at the current exponent. The second is whether it would leave the range one exponent step finer, where every value counts double.

When the end marker arrives, the exponent moves by at most one step. It goes up if any element overflowed at the current exponent. It goes down if every element would still fit one step finer. Otherwise it stays where it is. A freeze input keeps the exponent fixed, for example once training is over and the exponent is used for inference. The updated exponent appears one cycle after the end-marker beat, together with a one-cycle valid strobe.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle after reset has been released, so a beat is accepted in each cycle in which `in_valid` is high. Cycles with `in_valid` low carry no element and change nothing. The exponent output and the freeze input are plain level signals.

Top module: `dfp_scale_tracker`

## Requirements
- R1: After reset, `exp_out` equals the preset `INIT_EXP` (default 0), `exp_valid` is low, and `in_ready` is high from the first cycle after reset is released.
- R2: A value `v` overflows at exponent `e` exactly when `floor(v · 2^-(FRAC_BITS+e))` lies outside [-128, 127], with `FRAC_BITS` = 8 by default. This holds for both right-shift exponents and left-shift exponents (`FRAC_BITS+e` < 0).
- R3: If any element of a tensor overflows at the current exponent, the exponent rises by one at the end marker.
- R4: If no element of a tensor overflows at the current exponent minus one, the exponent falls by one at the end marker.
- R5: In every other case the exponent keeps its value at the end marker.
- R6: The exponent is a 6-bit signed value and saturates at its limits: a fall decided at -32 leaves it at -32, and a rise decided at 31 leaves it at 31.
- R7: While `freeze` is high on the end-marker beat, the exponent does not change, and `exp_valid` still pulses.
- R8: A beat with the start marker (`in_first`) discards the overflow history of all earlier beats. Beats accepted outside a tensor therefore have no effect on the next decision.
- R9: `exp_out` changes, and `exp_valid` is high, only in the cycle after an accepted beat with `in_last`. `exp_valid` stays high for that one cycle per such beat. Cycles with `in_valid` low are ignored whatever `in_data` holds.
- R10: A beat that carries both markers forms a one-element tensor, and the decision depends on that element alone.
- R11: `in_ready` is never low after reset has been released. The block applies no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Element on `in_data` is present |
| in_ready | output | 1 | Block accepts an element (high after reset) |
| in_data | input | 32 | Signed element, `FRAC_BITS` fraction bits |
| in_first | input | 1 | Element opens the tensor |
| in_last | input | 1 | Element closes the tensor |
| freeze | input | 1 | Hold the exponent at the end of the tensor |
| exp_out | output | 6 | Signed exponent currently in force |
| exp_valid | output | 1 | One-cycle strobe: `exp_out` was just updated |

## Verification
Some properties are checked on every cycle. The exponent moves by at most one step, and only after an end-marker beat. The strobe follows each end-marker beat by exactly one cycle. A frozen update leaves the exponent unchanged. The saturation limits hold. An overflow at the current exponent always comes with an overflow at the finer one. The history flags are empty after each end marker. `in_ready` stays high once reset is released.

Other behaviours can only be shown by the bench's scenarios, because they need a known stream of values. These are the exact overflow boundaries on both shift directions, the choice between rise, fall and hold for a given tensor, the effect of the start marker on stray beats, single-element tensors, and the descent to the lower saturation limit.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } exp_step_e;

  // Two-test rule: an overflow at the current scale wins; otherwise, if all
  // doubled values still fit, move finer; freeze overrides both.
  function automatic exp_step_e pick_step(input logic any_coarse,
                                          input logic any_fine,
                                          input logic hold_req);
    exp_step_e s;
    if (hold_req)        s = STEP_HOLD;
    else if (any_coarse) s = STEP_UP;
    else if (!any_fine)  s = STEP_DOWN;
    else                 s = STEP_HOLD;
    return s;
  endfunction

endpackage

// File: rtl/dfp_range_check.sv
module dfp_range_check #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int SH_W   = 16,
  parameter int WIDE_W = 58
) (
  input  logic signed [DATA_W-1:0] value,
  input  logic signed [SH_W-1:0]   shift,
  output logic                     out_of_range
);

  localparam logic signed [WIDE_W-1:0] CODE_HI = WIDE_W'(2 ** (CODE_W - 1) - 1);
  localparam logic signed [WIDE_W-1:0] CODE_LO = -WIDE_W'(2 ** (CODE_W - 1));

  logic signed [WIDE_W-1:0] widened;
  logic signed [WIDE_W-1:0] scaled;
  logic        [SH_W-1:0]   amount;

  // Positive shift: drop fraction bits (floor). Negative shift: the scale is
  // finer than one LSB, so the value grows by a left shift in a wide word.
  always_comb begin
    widened = {{(WIDE_W - DATA_W){value[DATA_W-1]}}, value};
    if (shift[SH_W-1]) begin
      amount = $unsigned(-shift);
      scaled = widened <<< amount;
    end else begin
      amount = $unsigned(shift);
      scaled = widened >>> amount;
    end
  end

  assign out_of_range = (scaled > CODE_HI) || (scaled < CODE_LO);

endmodule

// File: rtl/dfp_flag_accum.sv
module dfp_flag_accum (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic beat_first,
  input  logic beat_last,
  input  logic hit_coarse,
  input  logic hit_fine,
  output logic any_coarse,
  output logic any_fine
);

  logic seen_coarse_q;
  logic seen_fine_q;
  logic base_coarse;
  logic base_fine;

  // The start marker discards the history; the current beat is always merged
  // so the end-marker beat contributes to its own decision.
  always_comb begin
    base_coarse = beat_first ? 1'b0 : seen_coarse_q;
    base_fine   = beat_first ? 1'b0 : seen_fine_q;
    any_coarse  = beat ? (base_coarse | hit_coarse) : seen_coarse_q;
    any_fine    = beat ? (base_fine | hit_fine) : seen_fine_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_coarse_q <= 1'b0;
      seen_fine_q   <= 1'b0;
    end else if (beat) begin
      if (beat_last) begin
        seen_coarse_q <= 1'b0;
        seen_fine_q   <= 1'b0;
      end else begin
        seen_coarse_q <= base_coarse | hit_coarse;
        seen_fine_q   <= base_fine | hit_fine;
      end
    end
  end

  // R8: history is empty right after a tensor closes
  assert_clear_after_last_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat && beat_last) |-> (!seen_coarse_q && !seen_fine_q));

  // R2: an overflow at the coarse scale implies one at the finer scale
  assert_fine_covers_coarse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    seen_coarse_q |-> seen_fine_q);

endmodule

// File: rtl/dfp_exp_reg.sv
module dfp_exp_reg
  import dfp_pkg::*;
#(
  parameter int EXP_W    = 6,
  parameter int INIT_EXP = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    update,
  input  exp_step_e               step,
  output logic signed [EXP_W-1:0] exp_q,
  output logic                    strobe_q
);

  localparam logic signed [EXP_W-1:0] EXP_MAX = EXP_W'(2 ** (EXP_W - 1) - 1);
  localparam logic signed [EXP_W-1:0] EXP_MIN = -EXP_W'(2 ** (EXP_W - 1));

  logic signed [EXP_W-1:0] exp_next;

  always_comb begin
    exp_next = exp_q;
    unique case (step)
      STEP_UP:   if (exp_q != EXP_MAX) exp_next = exp_q + EXP_W'(1);
      STEP_DOWN: if (exp_q != EXP_MIN) exp_next = exp_q - EXP_W'(1);
      default:   exp_next = exp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q    <= EXP_W'(INIT_EXP);
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= update;
      if (update) exp_q <= exp_next;
    end
  end

  // R9: the exponent holds between updates
  assert_exp_stable_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !$past(update) |-> $stable(exp_q));

  // R3/R4: one step at most per update
  assert_single_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(update) |-> ((exp_q == $past(exp_q)) ||
                       (exp_q == $past(exp_q) + EXP_W'(1)) ||
                       (exp_q == $past(exp_q) - EXP_W'(1))));

  // R6: saturation at both ends
  assert_sat_low_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(update && step == STEP_DOWN && exp_q == EXP_MIN) |-> exp_q == EXP_MIN);
  assert_sat_high_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(update && step == STEP_UP && exp_q == EXP_MAX) |-> exp_q == EXP_MAX);

endmodule

// File: rtl/dfp_scale_tracker.sv
module dfp_scale_tracker
  import dfp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CODE_W    = 8,
  parameter int EXP_W     = 6,
  parameter int FRAC_BITS = 8,
  parameter int INIT_EXP  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic                     freeze,
  output logic signed [EXP_W-1:0]  exp_out,
  output logic                     exp_valid
);

  localparam int SH_W      = 16;
  localparam int EXP_MIN_I = -(2 ** (EXP_W - 1));
  localparam int SH_LOWEST = EXP_MIN_I + FRAC_BITS - 1;
  localparam int LSH_MAX   = (SH_LOWEST < 0) ? -SH_LOWEST : 0;
  localparam int WIDE_W    = DATA_W + LSH_MAX + 1;
  localparam int N_TESTS   = 2;   // index 0: current scale, 1: one step finer

  logic                   ready_q;
  logic                   beat;
  logic                   beat_last;
  logic signed [SH_W-1:0] shift_base;
  logic [N_TESTS-1:0]     hit;
  logic                   any_coarse;
  logic                   any_fine;
  exp_step_e              step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready  = ready_q;
  assign beat      = in_valid && ready_q;
  assign beat_last = beat && in_last;

  assign shift_base = SH_W'(FRAC_BITS) + {{(SH_W - EXP_W){exp_out[EXP_W-1]}}, exp_out};

  for (genvar gi = 0; gi < N_TESTS; gi++) begin : g_test
    logic signed [SH_W-1:0] shift_g;
    assign shift_g = shift_base - SH_W'(gi);
    dfp_range_check #(
      .DATA_W (DATA_W),
      .CODE_W (CODE_W),
      .SH_W   (SH_W),
      .WIDE_W (WIDE_W)
    ) u_check (
      .value        (in_data),
      .shift        (shift_g),
      .out_of_range (hit[gi])
    );
  end

  dfp_flag_accum u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .beat_first (in_first),
    .beat_last  (in_last),
    .hit_coarse (hit[0]),
    .hit_fine   (hit[1]),
    .any_coarse (any_coarse),
    .any_fine   (any_fine)
  );

  assign step = pick_step(any_coarse, any_fine, freeze);

  dfp_exp_reg #(
    .EXP_W    (EXP_W),
    .INIT_EXP (INIT_EXP)
  ) u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .update   (beat_last),
    .step     (step),
    .exp_q    (exp_out),
    .strobe_q (exp_valid)
  );

  // R9: strobe exactly one cycle after each end-marker beat
  assert_strobe_follows_last_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> exp_valid);
  assert_strobe_has_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid |-> $past(beat_last));

  // R7: frozen update keeps the exponent
  assert_freeze_holds_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat_last && freeze) |-> exp_out == $past(exp_out));

  // R11: no back-pressure once out of reset
  assert_always_ready_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R2: a value outside the coarse range is also outside the finer range
  assert_fine_implies_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (beat && hit[0]) |-> hit[1]);

endmodule

// File: tb/test_dfp_scale_tracker.sv
module test_dfp_scale_tracker;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [31:0] in_data = '0;
  logic               in_first = 1'b0;
  logic               in_last = 1'b0;
  logic               freeze = 1'b0;
  logic signed [5:0]  exp_out;
  logic               exp_valid;

  int checks = 0;
  int errors = 0;
  int e_model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  dfp_scale_tracker i_dfp_scale_tracker (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .in_first (in_first), .in_last (in_last),
    .freeze (freeze), .exp_out (exp_out), .exp_valid (exp_valid)
  );

  typedef struct packed {
    logic signed [31:0] a;
    logic signed [31:0] b;
    logic signed [31:0] c;
    logic signed [7:0]  exp_after;
  } vec_t;

  // Three-beat tensors, starting at exponent 0, FRAC_BITS = 8 (R2..R5)
  localparam vec_t VECS [10] = '{
    '{32'sd100,        -32'sd200,   32'sd300, -8'sd1},  // R4 fall
    '{32'sd10000,       32'sd5,    -32'sd5,   -8'sd1},  // R5 hold
    '{32'sd16384,       32'sd0,     32'sd0,    8'sd0},  // R3 rise
    '{-32'sd32768,      32'sd1,     32'sd2,    8'sd0},  // R5 hold at low edge
    '{-32'sd32769,      32'sd0,     32'sd0,    8'sd1},  // R3 rise
    '{32'sd32767,      -32'sd32768, 32'sd0,    8'sd0},  // R4 fall
    '{32'sd0,           32'sd0,     32'sd0,   -8'sd1},  // R4 fall
    '{-32'sd16384,      32'sd16383, 32'sd0,   -8'sd1},  // R5 hold
    '{-32'sd16385,      32'sd0,     32'sd0,    8'sd0},  // R3 rise
    '{32'sd2147483647,  32'sd0,     32'sd0,    8'sd1}   // R3 rise, full scale
  };

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic beat(input logic signed [31:0] v, input logic f, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = v; in_first = f; in_last = l;
  endtask

  // After the end-marker beat: next negedge shows the strobe and new value,
  // the one after shows the strobe gone.
  task automatic finish_tensor(input string req, input int expv);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    chk({req, " exp_valid pulse"}, int'(exp_valid), 1);
    chk({req, " exponent"}, int'(exp_out), expv);
    @(negedge clk);
    chk({req, " exp_valid one cycle (R9)"}, int'(exp_valid), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset exponent", int'(exp_out), 0);
    chk("R1 reset exp_valid", int'(exp_valid), 0);
    chk("R11 ready after reset", int'(in_ready), 1);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      beat(VECS[i].a, 1'b1, 1'b0);
      beat(VECS[i].b, 1'b0, 1'b0);
      beat(VECS[i].c, 1'b0, 1'b1);
      e_model = int'(VECS[i].exp_after);
      finish_tensor($sformatf("R2-vector%0d", i), e_model);
    end
    chk("R11 ready during traffic", int'(in_ready), 1);

    // R8: stray overflowing beat outside a tensor is discarded by the start marker
    beat(32'sd2147483647, 1'b0, 1'b0);
    beat(32'sd0, 1'b1, 1'b0);
    beat(32'sd0, 1'b0, 1'b1);
    e_model = 0;
    finish_tensor("R8 start clears history", e_model);

    // R10: one-element tensors
    beat(32'sd40000, 1'b1, 1'b1);
    e_model = 1;
    finish_tensor("R10 single-beat rise", e_model);
    beat(32'sd0, 1'b1, 1'b1);
    e_model = 0;
    finish_tensor("R10 single-beat fall", e_model);

    // R9: idle cycle with a huge value on the bus is ignored
    beat(32'sd5, 1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'sd2147483647; in_first = 1'b0; in_last = 1'b0;
    chk("R9 no strobe mid-tensor", int'(exp_valid), 0);
    chk("R9 exponent unchanged mid-tensor", int'(exp_out), 0);
    beat(32'sd5, 1'b0, 1'b1);
    e_model = -1;
    finish_tensor("R9 invalid cycle ignored", e_model);

    // R7: freeze holds despite overflow
    freeze = 1'b1;
    beat(32'sd2147483647, 1'b1, 1'b1);
    finish_tensor("R7 freeze holds", e_model);
    freeze = 1'b0;

    // R6: descend to the lower limit and stay there
    for (int k = 0; k < 34; k++) begin
      beat(32'sd0, 1'b1, 1'b1);
      e_model = (e_model > -32) ? e_model - 1 : -32;
      finish_tensor("R6 descent", e_model);
    end
    chk("R6 saturated at -32", int'(exp_out), -32);

    // R2: left-shift scales, value of one LSB overflows at very fine exponents
    beat(32'sd1, 1'b1, 1'b1);
    e_model = -31;
    finish_tensor("R2 left-shift positive", e_model);
    beat(-32'sd1, 1'b1, 1'b1);
    e_model = -30;
    finish_tensor("R2 left-shift negative", e_model);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule